// File: doc/BRIEF.md
# Serial Receive Engine with Address Filter

This block turns an asynchronous serial line into a stream of stored characters. A baud tick arrives sixteen times per bit period. The engine waits for a falling edge, confirms the start bit halfway through it, then takes three votes around the middle of each later bit. It assembles a character of 8 or 9 data bits, least significant bit first. An optional parity bit is checked in 8-bit mode. A stop bit follows. Each finished character goes into a four-entry queue, together with a parity-error flag and a framing-error flag.

A consumer drains the queue through a valid/ready pair. The head entry is visible whenever the queue is not empty. A flow-control output tells the far end to hold off while the queue is full. A one-cycle interrupt marks every stored character. A character that finishes while the queue is full is lost, and a sticky overrun flag records the loss.

In 9-bit mode an address filter can be enabled. With the filter on, only characters whose ninth bit is set are kept. A diagnostic select makes the receiver listen to a local transmitter output instead of the external pin.

Top module: `sio_rx_engine`

## Requirements
- R1: After reset, rd_valid, overrun and rx_irq are 0 and rts is 1.
- R2: A frame consists of a start bit (low), 8 data bits (cfg_nine=0) or 9 data bits (cfg_nine=1) sent LSB first, an optional parity bit and a stop bit (high), with each bit lasting 16 baud ticks. Such a frame is stored with its data on rd_data. In 8-bit mode rd_data[8] reads 0.
- R3: The start bit is re-sampled at tick 8 of its 16 ticks. If the line is high again at that tick, the frame is abandoned and nothing is stored.
- R4: Each data, parity and stop bit takes the majority of the samples at ticks 7, 8 and 9 of its bit period, so a one-tick glitch at tick 8 does not change the received value.
- R5: cfg_parity 2'b01 selects even parity and 2'b10 selects odd parity. 2'b00 and 2'b11 select no parity bit. A parity bit is present only when cfg_nine=0. When the received parity does not match, rd_perr=1 is stored with the character.
- R6: A stop bit that resolves low sets rd_ferr=1 for that character, and the character is still stored.
- R7: The queue holds 4 entries and returns them in arrival order. The head entry is shown while rd_valid=1, and one entry is removed on each cycle where rd_valid and rd_ready are both 1.
- R8: A character that is to be stored while the queue holds 4 entries is discarded, even if an entry is removed in the same cycle. It sets overrun, which stays 1 until ovr_clear is pulsed. If a new overrun and ovr_clear occur in the same cycle, overrun stays set.
- R9: With cfg_nine=1 and cfg_addr_only=1, characters whose ninth bit is 0 are dropped. A dropped character raises neither rx_irq nor overrun.
- R10: cfg_loopback=1 makes the receiver listen to lb_tx and ignore rx_pin. cfg_loopback=0 makes it listen to rx_pin and ignore lb_tx.
- R11: rts is 1 while the queue holds fewer than 4 entries and 0 when it holds 4.
- R12: rx_irq pulses for one cycle per stored character, in the first cycle in which that character is present in the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| rx_pin | input | 1 | External serial line, idle high |
| lb_tx | input | 1 | Local transmitter output for loopback |
| cfg_loopback | input | 1 | 1 selects lb_tx as the receive line |
| cfg_nine | input | 1 | 1 selects 9 data bits |
| cfg_parity | input | 2 | 01 even, 10 odd, otherwise none |
| cfg_addr_only | input | 1 | In 9-bit mode, keep only characters with bit 8 set |
| ovr_clear | input | 1 | Clears the overrun flag |
| rd_ready | input | 1 | Consumer takes the head entry |
| rd_valid | output | 1 | Queue is not empty |
| rd_data | output | 9 | Head character |
| rd_perr | output | 1 | Parity error of the head character |
| rd_ferr | output | 1 | Framing error of the head character |
| overrun | output | 1 | Sticky lost-character flag |
| rts | output | 1 | 1 while the queue can accept a character |
| rx_irq | output | 1 | Pulse per stored character |

## Verification
The assertions assume that the configuration inputs stay constant while a frame is being received. The address-filter property also assumes that consecutive characters are more than two cycles apart, which is always true with a 16-tick bit period. The stimulus changes the configuration only between frames, while the line is idle. It always drives whole bit periods aligned to the baud tick, and it inserts glitches only at tick 8 of data and stop bits, never inside the start bit.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;

  localparam int CHAR_W = 9;

  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

  typedef struct packed {
    logic              perr;
    logic              ferr;
    logic [CHAR_W-1:0] data;
  } rx_char_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

endpackage

// File: rtl/sio_rx_sampler.sv
module sio_rx_sampler
  import sio_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line_in,
  input  logic       nine,
  input  logic [1:0] par_mode,
  output logic       done,
  output rx_char_t   frame
);

  localparam int PW = $clog2(OSR);
  localparam int BW = $clog2(CHAR_W);
  localparam logic [PW-1:0] PH_PRE  = PW'(OSR / 2 - 1);
  localparam logic [PW-1:0] PH_MID  = PW'(OSR / 2);
  localparam logic [PW-1:0] PH_POST = PW'(OSR / 2 + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(OSR - 1);

  // line synchroniser
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
  end
  assign line = sync_q[SYNC_STAGES-1];

  rx_state_t         state_q, state_d;
  logic [PW-1:0]     phase_q, phase_d;
  logic [BW-1:0]     bitn_q, bitn_d;
  logic [CHAR_W-1:0] shift_q, shift_d;
  logic [1:0]        vote_q, vote_d;
  logic              parbit_q, parbit_d;
  logic              done_q, done_d;
  rx_char_t          frame_q, frame_d;

  logic              majority;
  logic              par_en;
  logic [BW-1:0]     last_bit;
  logic [CHAR_W-1:0] char_val;

  assign majority = (vote_q[0] & vote_q[1]) | (line & (vote_q[0] | vote_q[1]));
  assign par_en   = !nine && (par_mode == PAR_EVEN || par_mode == PAR_ODD);
  assign last_bit = nine ? BW'(CHAR_W - 1) : BW'(CHAR_W - 2);
  assign char_val = nine ? shift_q : {1'b0, shift_q[CHAR_W-1:1]};

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    bitn_d   = bitn_q;
    shift_d  = shift_q;
    vote_d   = vote_q;
    parbit_d = parbit_q;
    frame_d  = frame_q;
    done_d   = 1'b0;
    if (tick) begin
      if (state_q != ST_IDLE) begin
        phase_d = phase_q + 1'b1;
        if (phase_q == PH_PRE) vote_d[0] = line;
        if (phase_q == PH_MID) vote_d[1] = line;
      end
      case (state_q)
        ST_IDLE: begin
          if (!line) begin
            state_d = ST_START;
            phase_d = PW'(1);
          end
        end
        ST_START: begin
          if (phase_q == PH_MID && line) begin
            state_d = ST_IDLE;
            phase_d = '0;
          end else if (phase_q == PH_LAST) begin
            state_d = ST_DATA;
            phase_d = '0;
            bitn_d  = '0;
          end
        end
        ST_DATA: begin
          if (phase_q == PH_POST) shift_d = {majority, shift_q[CHAR_W-1:1]};
          if (phase_q == PH_LAST) begin
            phase_d = '0;
            if (bitn_q == last_bit) state_d = par_en ? ST_PAR : ST_STOP;
            else                    bitn_d  = bitn_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (phase_q == PH_POST) parbit_d = majority;
          if (phase_q == PH_LAST) begin
            phase_d = '0;
            state_d = ST_STOP;
          end
        end
        ST_STOP: begin
          if (phase_q == PH_POST) begin
            state_d      = ST_IDLE;
            phase_d      = '0;
            done_d       = 1'b1;
            frame_d.data = char_val;
            frame_d.ferr = !majority;
            frame_d.perr = par_en &&
                           (((^char_val[7:0]) ^ parbit_q) != (par_mode == PAR_ODD));
          end
        end
        default: begin
          state_d = ST_IDLE;
          phase_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      phase_q  <= '0;
      bitn_q   <= '0;
      shift_q  <= '0;
      vote_q   <= '0;
      parbit_q <= 1'b0;
      done_q   <= 1'b0;
      frame_q  <= '0;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      bitn_q   <= bitn_d;
      shift_q  <= shift_d;
      vote_q   <= vote_d;
      parbit_q <= parbit_d;
      done_q   <= done_d;
      frame_q  <= frame_d;
    end
  end

  assign done  = done_q;
  assign frame = frame_q;

endmodule

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = do_push ? bump(wr_q) : wr_q;
    rd_d  = do_pop  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && wr_q == AW'(i)) mem[i] <= push_data;
    end
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;

endmodule

// File: rtl/sio_rx_engine.sv
module sio_rx_engine
  import sio_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        baud_tick,
  input  logic        rx_pin,
  input  logic        lb_tx,
  input  logic        cfg_loopback,
  input  logic        cfg_nine,
  input  logic [1:0]  cfg_parity,
  input  logic        cfg_addr_only,
  input  logic        ovr_clear,
  input  logic        rd_ready,
  output logic        rd_valid,
  output logic [8:0]  rd_data,
  output logic        rd_perr,
  output logic        rd_ferr,
  output logic        overrun,
  output logic        rts,
  output logic        rx_irq
);

  localparam int EW = $bits(rx_char_t);
  localparam int CW = $clog2(DEPTH + 1);

  logic          line_sel;
  logic          smp_done;
  rx_char_t      smp_char;
  rx_char_t      head;
  logic [CW-1:0] fill;
  logic          full, empty, keep, push;
  logic          ovr_q, ovr_d, irq_q, irq_d;

  assign line_sel = cfg_loopback ? lb_tx : rx_pin;

  sio_rx_sampler #(
    .OSR         (OSR),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (baud_tick),
    .line_in  (line_sel),
    .nine     (cfg_nine),
    .par_mode (cfg_parity),
    .done     (smp_done),
    .frame    (smp_char)
  );

  // address filter ahead of the queue
  assign keep = smp_done &&
                !(cfg_nine && cfg_addr_only && !smp_char.data[CHAR_W-1]);
  assign push = keep && !full;

  sio_rx_fifo #(
    .WIDTH (EW),
    .DEPTH (DEPTH)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (smp_char),
    .pop       (rd_valid && rd_ready),
    .head      (head),
    .count     (fill),
    .full      (full),
    .empty     (empty)
  );

  always_comb begin
    ovr_d = ovr_q;
    if (ovr_clear)    ovr_d = 1'b0;
    if (keep && full) ovr_d = 1'b1;
    irq_d = push;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ovr_q <= ovr_d;
      irq_q <= irq_d;
    end
  end

  assign rd_valid = !empty;
  assign rd_data  = head.data;
  assign rd_perr  = head.perr;
  assign rd_ferr  = head.ferr;
  assign overrun  = ovr_q;
  assign rts      = !full;
  assign rx_irq   = irq_q;

endmodule

// File: rtl/sio_rx_checker.sv
module sio_rx_checker #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [8:0]    rd_data,
  input logic          overrun,
  input logic          ovr_clear,
  input logic          rts,
  input logic          rx_irq,
  input logic          cfg_nine,
  input logic          cfg_addr_only,
  input logic [CW-1:0] fill
);

  // R11: flow control follows queue occupancy
  p_rts_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == CW'(DEPTH)) == !rts);

  // R12: interrupt lasts one cycle
  p_irq_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  // R12: interrupt coincides with a visible entry
  p_irq_visible_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rd_valid);

  // R8: overrun is sticky until cleared
  p_ovr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_clear |=> overrun);

  // R8: overrun only rises when the queue was full
  p_ovr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(fill) == CW'(DEPTH));

  // R8: nothing is stored into a full queue
  p_full_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill) == CW'(DEPTH)) && !$past(rd_valid && rd_ready) |-> !rx_irq);

  // R9: filtered mode stores only characters with bit 8 set
  p_addr_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq && $past(fill) == '0 && cfg_nine && cfg_addr_only |-> rd_data[8]);

endmodule

bind sio_rx_engine sio_rx_checker #(
  .DEPTH (DEPTH),
  .CW    (CW)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rd_valid      (rd_valid),
  .rd_ready      (rd_ready),
  .rd_data       (rd_data),
  .overrun       (overrun),
  .ovr_clear     (ovr_clear),
  .rts           (rts),
  .rx_irq        (rx_irq),
  .cfg_nine      (cfg_nine),
  .cfg_addr_only (cfg_addr_only),
  .fill          (fill)
);

// File: tb/sio_rx_engine_test.sv
`timescale 1ns/1ps
module sio_rx_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int OSR        = 16;

  logic       clk, rst_n, baud_tick, rx_pin, lb_tx;
  logic       c_lb, c_nine, c_addr, ovr_clear, rd_ready;
  logic [1:0] c_par;
  logic       rd_valid, rd_perr, rd_ferr, overrun, rts, rx_irq;
  logic [8:0] rd_data;

  int total = 0;
  int bad   = 0;
  int irq_seen = 0;
  int irq_exp  = 0;
  int tdiv = 0;

  sio_rx_engine uut (
    .clk (clk), .rst_n (rst_n), .baud_tick (baud_tick),
    .rx_pin (rx_pin), .lb_tx (lb_tx), .cfg_loopback (c_lb),
    .cfg_nine (c_nine), .cfg_parity (c_par), .cfg_addr_only (c_addr),
    .ovr_clear (ovr_clear), .rd_ready (rd_ready), .rd_valid (rd_valid),
    .rd_data (rd_data), .rd_perr (rd_perr), .rd_ferr (rd_ferr),
    .overrun (overrun), .rts (rts), .rx_irq (rx_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) tdiv <= 0;
    else        tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    if (rst_n && rx_irq) irq_seen <= irq_seen + 1;
  end
  assign baud_tick = rst_n && (tdiv == TICK_DIV - 1);

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish (got timeout, expected completion)");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_tick();
    @(posedge clk iff baud_tick);
    @(negedge clk);
  endtask

  task automatic set_line(input logic v, input bit via_lb);
    if (via_lb) lb_tx = v;
    else        rx_pin = v;
  endtask

  task automatic send_bit(input logic v, input bit via_lb, input bit glitch);
    set_line(v, via_lb);
    for (int t = 1; t <= OSR; t++) begin
      wait_tick();
      if (glitch && t == 8) set_line(!v, via_lb);
      if (glitch && t == 9) set_line(v, via_lb);
    end
  endtask

  task automatic send_frame(input logic [8:0] d, input bit bad_par,
                            input bit bad_stop, input bit glitch, input bit via_lb);
    int nb;
    logic p;
    nb = c_nine ? 9 : 8;
    send_bit(1'b0, via_lb, 1'b0);
    for (int i = 0; i < nb; i++) send_bit(d[i], via_lb, glitch);
    if (!c_nine && (c_par == 2'b01 || c_par == 2'b10)) begin
      p = (^d[7:0]) ^ (c_par == 2'b10) ^ bad_par;
      send_bit(p, via_lb, glitch);
    end
    send_bit(!bad_stop, via_lb, glitch);
    send_bit(1'b1, via_lb, 1'b0);
  endtask

  function automatic logic [8:0] exp_data(input logic [8:0] d);
    return c_nine ? d : {1'b0, d[7:0]};
  endfunction

  function automatic bit exp_perr(input bit bad_par);
    return !c_nine && (c_par == 2'b01 || c_par == 2'b10) && bad_par;
  endfunction

  function automatic bit exp_keep(input logic [8:0] d);
    return !(c_nine && c_addr && !d[8]);
  endfunction

  task automatic pop_check(input logic [8:0] d, input bit pe, input bit fe,
                           input string req);
    chk(rd_valid == 1'b1, req, "rd_valid", int'(rd_valid), 1);
    chk(rd_data == d, req, "rd_data", int'(rd_data), int'(d));
    chk(rd_perr == pe, req, "rd_perr", int'(rd_perr), int'(pe));
    chk(rd_ferr == fe, req, "rd_ferr", int'(rd_ferr), int'(fe));
    rd_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    chk(rd_valid == 1'b0, req, "rd_valid", int'(rd_valid), 0);
  endtask

  task automatic set_cfg(input bit n, input logic [1:0] p, input bit a);
    c_nine = n;
    c_par  = p;
    c_addr = a;
  endtask

  task automatic one(input logic [8:0] d, input bit bp, input bit bs,
                     input bit gl, input string req);
    send_frame(d, bp, bs, gl, c_lb);
    if (exp_keep(d)) begin
      irq_exp++;
      pop_check(exp_data(d), exp_perr(bp), bs, req);
    end else begin
      expect_empty(req);
    end
  endtask

  initial begin
    logic [8:0] fill_vals [4];
    void'($urandom(32'h1234abcd));
    rst_n = 1'b0; rx_pin = 1'b1; lb_tx = 1'b1; c_lb = 1'b0;
    ovr_clear = 1'b0; rd_ready = 1'b0;
    set_cfg(1'b0, 2'b00, 1'b0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(rd_valid == 1'b0, "R1", "rd_valid", int'(rd_valid), 0);
    chk(overrun == 1'b0, "R1", "overrun", int'(overrun), 0);
    chk(rts == 1'b1, "R1", "rts", int'(rts), 1);
    chk(rx_irq == 1'b0, "R1", "rx_irq", int'(rx_irq), 0);

    // R2: basic 8-bit and 9-bit frames
    one(9'h1A5, 0, 0, 0, "R2");
    set_cfg(1'b1, 2'b00, 1'b0);
    one(9'h15A, 0, 0, 0, "R2");
    one(9'h0C3, 0, 0, 0, "R2");

    // R5: parity modes
    set_cfg(1'b0, 2'b01, 1'b0);
    one(9'h03C, 0, 0, 0, "R5");
    one(9'h03D, 1, 0, 0, "R5");
    set_cfg(1'b0, 2'b10, 1'b0);
    one(9'h007, 0, 0, 0, "R5");
    one(9'h0F0, 1, 0, 0, "R5");
    set_cfg(1'b0, 2'b11, 1'b0);
    one(9'h081, 1, 0, 0, "R5");
    set_cfg(1'b1, 2'b01, 1'b0);
    one(9'h0F3, 1, 0, 0, "R5");

    // R6: stop bit low
    set_cfg(1'b0, 2'b00, 1'b0);
    one(9'h055, 0, 1, 0, "R6");

    // R3: start pulse too short
    rx_pin = 1'b0;
    repeat (3) wait_tick();
    rx_pin = 1'b1;
    repeat (40) wait_tick();
    expect_empty("R3");

    // R4: one-tick glitch at mid-bit
    one(9'h096, 0, 0, 1, "R4");
    set_cfg(1'b0, 2'b10, 1'b0);
    one(9'h0E1, 0, 0, 1, "R4");

    // R10: loopback path with garbage on the pin
    set_cfg(1'b0, 2'b00, 1'b0);
    c_lb = 1'b1;
    rx_pin = 1'b0;
    one(9'h0B7, 0, 0, 0, "R10");
    rx_pin = 1'b1;
    repeat (4) wait_tick();
    c_lb = 1'b0;
    repeat (4) wait_tick();
    send_frame(9'h012, 0, 0, 0, 1'b1);
    expect_empty("R10");

    // R9: address filter
    set_cfg(1'b1, 2'b00, 1'b1);
    one(9'h055, 0, 0, 0, "R9");
    chk(rx_irq == 1'b0 && irq_seen == irq_exp, "R9", "irq count", irq_seen, irq_exp);
    one(9'h1AA, 0, 0, 0, "R9");

    // R11/R8/R7: fill the queue, then overflow it
    fill_vals[0] = 9'h101; fill_vals[1] = 9'h1F2;
    fill_vals[2] = 9'h133; fill_vals[3] = 9'h1C4;
    for (int k = 0; k < 4; k++) begin
      send_frame(fill_vals[k], 0, 0, 0, 1'b0);
      irq_exp++;
      if (k == 2) chk(rts == 1'b1, "R11", "rts at 3", int'(rts), 1);
    end
    chk(rts == 1'b0, "R11", "rts at 4", int'(rts), 0);
    send_frame(9'h0EE, 0, 0, 0, 1'b0);
    chk(overrun == 1'b0, "R9", "overrun after filtered char", int'(overrun), 0);
    send_frame(9'h1EE, 0, 0, 0, 1'b0);
    chk(overrun == 1'b1, "R8", "overrun", int'(overrun), 1);
    chk(rts == 1'b0, "R11", "rts full", int'(rts), 0);
    for (int k = 0; k < 4; k++) pop_check(fill_vals[k], 0, 0, "R7");
    expect_empty("R8");
    chk(overrun == 1'b1, "R8", "overrun sticky", int'(overrun), 1);
    ovr_clear = 1'b1;
    @(negedge clk);
    ovr_clear = 1'b0;
    chk(overrun == 1'b0, "R8", "overrun cleared", int'(overrun), 0);

    // random frames
    for (int n = 0; n < 30; n++) begin
      logic [8:0] d;
      set_cfg(1'($urandom % 2), 2'($urandom % 4), 1'($urandom % 2));
      d = 9'($urandom);
      one(d, ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 3) == 0, "R2");
    end

    // R12: one interrupt per stored character
    chk(irq_seen == irq_exp, "R12", "irq count", irq_seen, irq_exp);

    summary();
    $finish;
  end

endmodule